// File: doc/BRIEF.md
# Keyed Multi-Source Reset Controller

This block merges three reset sources into one internal reset line. The sources are an external active-low reset pin, a watchdog expiry strobe and a software request. Software reaches the block through a byte-wide keyed register. Two writes to that register are judged as a pair. One pair services the watchdog. A second pair requests a software reset. Any other pair counts as a fault and forces a reset that is flagged as both causes at once.

Every internally generated reset is stretched to a fixed pulse length. The block keeps two sticky cause flags. These survive the pulse they caused, and the CPU clears them with write-one-to-clear strobes. A fuse input decides whether the pin is a reset input or a general-purpose input. During the power-up delay that follows the power-on indication, the pin always acts as a reset input. Holding the pin low during that delay keeps the whole power-up delay from ending.

Top module: `rkr_reset_ctrl`

## Requirements
- R1: While `por_n` is low, `rst_out` is 1 and both cause flags are 0. After `por_n` rises with the pin high, `rst_out` stays 1 for exactly PWRUP_CYCLES clock cycles and then falls.
- R2: During the power-up delay, a qualified low on the pin reloads the delay whatever the fuse value, so `rst_out` stays 1 until the pin has returned high.
- R3: With `fuse_pin_mode` = 1, a low pin triggers a reset only once the synchronised pin has been sampled low on QUAL_CYCLES (2) consecutive clock edges. A pin low for a single clock edge causes no reset. A qualified low holds `rst_out` at 1 while it lasts and for PULSE_LEN (16) cycles after it ends.
- R4: With `fuse_pin_mode` = 0 and power-up over, the pin never causes a reset, and its synchronised level appears on `gpio_in`. In reset-pin mode and during power-up, `gpio_in` reads 1.
- R5: A one-cycle `wdog_expired` strobe makes `rst_out` 1 for exactly 16 cycles, starting the cycle after the strobe is sampled. It also sets `cause_wdog` and leaves `cause_soft` unchanged.
- R6: Writing 0x1E and then 0xE1 to the keyed register gives a one-cycle `wdog_kick` pulse in the cycle after the second write. No reset follows and no flag changes.
- R7: Writing 0x5A and then 0xA5 gives a 16-cycle reset that starts the cycle after the second write. It sets `cause_soft` and leaves `cause_wdog` unchanged.
- R8: Any other byte pair gives an immediate 16-cycle reset and sets both `cause_wdog` and `cause_soft`.
- R9: The first write of a pair is latched and the second write completes the comparison, after which a new pair begins. Writes made while `rst_out` is 1 are ignored, and a half-written pair is dropped.
- R10: A new reset request that arrives while a pulse is running restarts the count, so `rst_out` stays 1 for a further 16 cycles from that request.
- R11: The cause flags are sticky. `flag_clr[0]` clears `cause_wdog` and `flag_clr[1]` clears `cause_soft`. If a set and a clear of the same flag arrive in the same cycle, the set wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| por_n | input | 1 | Power-on indication, active low, asynchronous assert |
| fuse_pin_mode | input | 1 | 1: pin is a reset input; 0: pin is a general-purpose input |
| rst_pin_n | input | 1 | External pin, asynchronous |
| key_wr | input | 1 | Write strobe for the keyed register |
| key_data | input | 8 | Byte written to the keyed register |
| wdog_expired | input | 1 | Watchdog expiry strobe |
| flag_clr | input | 2 | Write-one-to-clear strobes: bit 0 watchdog flag, bit 1 software flag |
| rst_out | output | 1 | Internal reset, active high |
| wdog_kick | output | 1 | One-cycle watchdog restart pulse |
| gpio_in | output | 1 | Synchronised pin level in general-purpose mode, else 1 |
| cause_wdog | output | 1 | Sticky watchdog-cause flag |
| cause_soft | output | 1 | Sticky software-cause flag |

## Verification
The bench builds the block with PWRUP_CYCLES set to 12. All other parameters keep their defaults: a 16-cycle pulse, two-edge pin qualification and a two-stage synchroniser. The short delay makes the exact power-up length affordable to count cycle by cycle, along with the case where a held-low pin keeps extending it. With the defaults, the single-edge glitch, the two-edge qualification and the exact 16-cycle pulses are observed exactly as the requirements state them.

// File: rtl/rkr_pkg.sv
package rkr_pkg;
   localparam logic [7:0] KEY_KICK_LO = 8'h1E;
   localparam logic [7:0] KEY_KICK_HI = 8'hE1;
   localparam logic [7:0] KEY_SOFT_LO = 8'h5A;
   localparam logic [7:0] KEY_SOFT_HI = 8'hA5;

   typedef enum logic [1:0] {
      VERDICT_NONE = 2'd0,
      VERDICT_KICK = 2'd1,
      VERDICT_SOFT = 2'd2,
      VERDICT_BAD  = 2'd3
   } key_verdict_e;
endpackage

// File: rtl/rkr_pin_qual.sv
module rkr_pin_qual #(
   parameter int SYNC_STAGES = 2,
   parameter int QUAL_CYCLES = 2
) (
   input  logic clk,
   input  logic por_n,
   input  logic pin_n,
   output logic pin_sync,
   output logic pin_req
);
   localparam int QW = $clog2(QUAL_CYCLES + 1);

   logic [SYNC_STAGES-1:0] sync_q;

   generate
      if (SYNC_STAGES < 1) begin : g_bad_sync
         $error("SYNC_STAGES must be at least 1");
      end
      if (QUAL_CYCLES < 1) begin : g_bad_qual
         $error("QUAL_CYCLES must be at least 1");
      end
   endgenerate

   genvar gi;
   generate
      for (gi = 0; gi < SYNC_STAGES; gi++) begin : g_sync
         always_ff @(posedge clk or negedge por_n) begin
            if (!por_n) sync_q[gi] <= 1'b1;
            else if (gi == 0) sync_q[gi] <= pin_n;
            else sync_q[gi] <= sync_q[(gi == 0) ? 0 : gi-1];
         end
      end
   endgenerate

   assign pin_sync = sync_q[SYNC_STAGES-1];

   generate
      if (QUAL_CYCLES == 1) begin : g_direct
         logic low_q;
         always_ff @(posedge clk or negedge por_n) begin
            if (!por_n) low_q <= 1'b0;
            else low_q <= ~pin_sync;
         end
         assign pin_req = low_q;
      end else begin : g_count
         logic [QW-1:0] low_cnt;
         always_ff @(posedge clk or negedge por_n) begin
            if (!por_n) low_cnt <= '0;
            else if (pin_sync) low_cnt <= '0;
            else if (low_cnt != QW'(QUAL_CYCLES)) low_cnt <= low_cnt + 1'b1;
         end
         assign pin_req = (low_cnt == QW'(QUAL_CYCLES));

         AST_TWO_LOW: assert property (@(posedge clk) disable iff (!por_n)
            pin_req |-> (!$past(pin_sync) && !$past(pin_sync, 2))); // R3
      end
   endgenerate
endmodule

// File: rtl/rkr_key_seq.sv
module rkr_key_seq
   import rkr_pkg::*;
(
   input  logic         clk,
   input  logic         por_n,
   input  logic         hold,
   input  logic         wr,
   input  logic [7:0]   wdata,
   output key_verdict_e verdict,
   output logic         kick
);
   logic       have_first;
   logic [7:0] first_q;
   logic       second;

   assign second = wr && have_first && !hold;

   always_comb begin
      verdict = VERDICT_NONE;
      if (second) begin
         if (first_q == KEY_KICK_LO && wdata == KEY_KICK_HI) verdict = VERDICT_KICK;
         else if (first_q == KEY_SOFT_LO && wdata == KEY_SOFT_HI) verdict = VERDICT_SOFT;
         else verdict = VERDICT_BAD;
      end
   end

   always_ff @(posedge clk or negedge por_n) begin
      if (!por_n) begin
         have_first <= 1'b0;
         first_q    <= '0;
         kick       <= 1'b0;
      end else begin
         kick <= (verdict == VERDICT_KICK);
         if (hold) begin
            have_first <= 1'b0;
         end else if (wr) begin
            if (!have_first) begin
               first_q    <= wdata;
               have_first <= 1'b1;
            end else begin
               have_first <= 1'b0;
            end
         end
      end
   end

   AST_PAIR_NEEDS_FIRST: assert property (@(posedge clk) disable iff (!por_n)
      (verdict != VERDICT_NONE) |=> !have_first); // R9
   AST_KICK_ONE_CYCLE: assert property (@(posedge clk) disable iff (!por_n)
      kick |=> !kick); // R6
endmodule

// File: rtl/rkr_stretch.sv
module rkr_stretch #(
   parameter int PULSE_LEN    = 16,
   parameter int PWRUP_CYCLES = 64
) (
   input  logic clk,
   input  logic por_n,
   input  logic req,
   input  logic pin_low,
   output logic pu_active,
   output logic pulse_busy
);
   localparam int CW = $clog2(PULSE_LEN + 1);
   localparam int PW = $clog2(PWRUP_CYCLES + 1);

   generate
      if (PULSE_LEN < 1) begin : g_bad_len
         $error("PULSE_LEN must be at least 1");
      end
      if (PWRUP_CYCLES < 1) begin : g_bad_pu
         $error("PWRUP_CYCLES must be at least 1");
      end
   endgenerate

   logic [CW-1:0] cnt;
   logic [PW-1:0] pu_cnt;

   always_ff @(posedge clk or negedge por_n) begin
      if (!por_n) cnt <= '0;
      else if (req) cnt <= CW'(PULSE_LEN);
      else if (cnt != '0) cnt <= cnt - 1'b1;
   end

   always_ff @(posedge clk or negedge por_n) begin
      if (!por_n) pu_cnt <= PW'(PWRUP_CYCLES);
      else if (pu_cnt != '0 && pin_low) pu_cnt <= PW'(PWRUP_CYCLES);
      else if (pu_cnt != '0) pu_cnt <= pu_cnt - 1'b1;
   end

   assign pu_active  = (pu_cnt != '0);
   assign pulse_busy = (cnt != '0);

   AST_REQ_ASSERTS: assert property (@(posedge clk) disable iff (!por_n)
      req |=> pulse_busy); // R10
   AST_NO_EARLY_RELEASE: assert property (@(posedge clk) disable iff (!por_n)
      $fell(pulse_busy) |-> !$past(req)); // R5
endmodule

// File: rtl/rkr_cause_flags.sv
module rkr_cause_flags (
   input  logic       clk,
   input  logic       por_n,
   input  logic       set_wdog,
   input  logic       set_soft,
   input  logic [1:0] clr,
   output logic       flag_wdog,
   output logic       flag_soft
);
   always_ff @(posedge clk or negedge por_n) begin
      if (!por_n) begin
         flag_wdog <= 1'b0;
         flag_soft <= 1'b0;
      end else begin
         if (set_wdog) flag_wdog <= 1'b1;
         else if (clr[0]) flag_wdog <= 1'b0;
         if (set_soft) flag_soft <= 1'b1;
         else if (clr[1]) flag_soft <= 1'b0;
      end
   end

   AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (!por_n)
      (flag_wdog && !clr[0]) |=> flag_wdog); // R11
   AST_SET_WINS: assert property (@(posedge clk) disable iff (!por_n)
      set_soft |=> flag_soft); // R11
endmodule

// File: rtl/rkr_reset_ctrl.sv
module rkr_reset_ctrl
   import rkr_pkg::*;
#(
   parameter int PULSE_LEN    = 16,
   parameter int PWRUP_CYCLES = 64,
   parameter int QUAL_CYCLES  = 2,
   parameter int SYNC_STAGES  = 2
) (
   input  logic       clk,
   input  logic       por_n,
   input  logic       fuse_pin_mode,
   input  logic       rst_pin_n,
   input  logic       key_wr,
   input  logic [7:0] key_data,
   input  logic       wdog_expired,
   input  logic [1:0] flag_clr,
   output logic       rst_out,
   output logic       wdog_kick,
   output logic       gpio_in,
   output logic       cause_wdog,
   output logic       cause_soft
);
   logic         pin_sync, pin_req, pin_eff, pin_is_reset;
   logic         pu_active, pulse_busy, any_req;
   key_verdict_e verdict;

   rkr_pin_qual #(.SYNC_STAGES(SYNC_STAGES), .QUAL_CYCLES(QUAL_CYCLES)) u_pin (
      .clk(clk), .por_n(por_n), .pin_n(rst_pin_n),
      .pin_sync(pin_sync), .pin_req(pin_req));

   assign pin_is_reset = fuse_pin_mode || pu_active;
   assign pin_eff      = pin_req && pin_is_reset;
   assign gpio_in      = pin_is_reset ? 1'b1 : pin_sync;

   rkr_key_seq u_key (
      .clk(clk), .por_n(por_n), .hold(rst_out), .wr(key_wr), .wdata(key_data),
      .verdict(verdict), .kick(wdog_kick));

   assign any_req = pin_eff || wdog_expired ||
                    (verdict == VERDICT_SOFT) || (verdict == VERDICT_BAD);

   rkr_stretch #(.PULSE_LEN(PULSE_LEN), .PWRUP_CYCLES(PWRUP_CYCLES)) u_str (
      .clk(clk), .por_n(por_n), .req(any_req), .pin_low(pin_req),
      .pu_active(pu_active), .pulse_busy(pulse_busy));

   assign rst_out = !por_n || pu_active || pulse_busy;

   rkr_cause_flags u_flags (
      .clk(clk), .por_n(por_n),
      .set_wdog(wdog_expired || verdict == VERDICT_BAD),
      .set_soft(verdict == VERDICT_SOFT || verdict == VERDICT_BAD),
      .clr(flag_clr), .flag_wdog(cause_wdog), .flag_soft(cause_soft));

   AST_WDOG_RESETS: assert property (@(posedge clk) disable iff (!por_n)
      wdog_expired |=> (rst_out && cause_wdog)); // R5
   AST_KICK_QUIET: assert property (@(posedge clk) disable iff (!por_n)
      wdog_kick |-> !$past(rst_out)); // R9
   AST_GPIO_NO_RESET: assert property (@(posedge clk) disable iff (!por_n)
      (!fuse_pin_mode && !pu_active && !wdog_expired && verdict == VERDICT_NONE && !rst_out)
      |=> !rst_out); // R4
endmodule

// File: tb/tb_rkr_reset_ctrl.sv
module tb_rkr_reset_ctrl;
   localparam int PU = 12;
   localparam int LEN = 16;

   logic clk = 0, por_n = 0, fuse_pin_mode = 1, rst_pin_n = 1;
   logic key_wr = 0, wdog_expired = 0;
   logic [7:0] key_data = 0;
   logic [1:0] flag_clr = 0;
   logic rst_out, wdog_kick, gpio_in, cause_wdog, cause_soft;
   int checks = 0, failures = 0;
   bit done = 0;

   always #10 clk = ~clk;

   rkr_reset_ctrl #(.PULSE_LEN(LEN), .PWRUP_CYCLES(PU)) dut (
      .clk(clk), .por_n(por_n), .fuse_pin_mode(fuse_pin_mode), .rst_pin_n(rst_pin_n),
      .key_wr(key_wr), .key_data(key_data), .wdog_expired(wdog_expired),
      .flag_clr(flag_clr), .rst_out(rst_out), .wdog_kick(wdog_kick),
      .gpio_in(gpio_in), .cause_wdog(cause_wdog), .cause_soft(cause_soft));

   task automatic chk(input string req, input int act, input int exp);
      checks++;
      if (act != exp) begin
         failures++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   task automatic measure(output int n);
      n = 0;
      while (rst_out && n < 200) begin n++; @(negedge clk); end
   endtask

   task automatic wr_key(input logic [7:0] b);
      key_wr = 1; key_data = b; @(negedge clk); key_wr = 0;
   endtask

   task automatic expire();
      wdog_expired = 1; @(negedge clk); wdog_expired = 0;
   endtask

   task automatic clear_flags();
      flag_clr = 2'b11; @(negedge clk); flag_clr = 2'b00;
   endtask

   task automatic power_on(input logic pin);
      por_n = 0; rst_pin_n = pin;
      repeat (3) @(negedge clk);
      chk("R1 rst during por", rst_out, 1);
      chk("R1 flags during por", {cause_wdog, cause_soft}, 0);
      por_n = 1;
   endtask

   task automatic t_power_on();
      int n;
      fuse_pin_mode = 1;
      power_on(1'b1);
      measure(n);
      chk("R1 power-up length", n, PU);
   endtask

   task automatic t_pin_mode();
      int n, seen;
      rst_pin_n = 0; @(negedge clk); rst_pin_n = 1;
      seen = 0;
      repeat (12) begin @(negedge clk); seen |= rst_out; end
      chk("R3 one-edge glitch ignored", seen, 0);
      rst_pin_n = 0; repeat (2) @(negedge clk); rst_pin_n = 1;
      seen = 0;
      for (int i = 0; i < 8 && !seen; i++) begin @(negedge clk); seen = rst_out; end
      chk("R3 qualified low resets", seen, 1);
      measure(n);
      chk("R3 stretch after pin", n, LEN);
   endtask

   task automatic t_wdog();
      int n;
      expire();
      chk("R5 rst next cycle", rst_out, 1);
      measure(n);
      chk("R5 pulse length", n, LEN);
      chk("R5 wdog flag", cause_wdog, 1);
      chk("R5 soft flag untouched", cause_soft, 0);
      clear_flags();
      chk("R11 clear both", {cause_wdog, cause_soft}, 0);
   endtask

   task automatic t_kick();
      int seen;
      wr_key(8'h1E); wr_key(8'hE1);
      chk("R6 kick pulse", wdog_kick, 1);
      chk("R6 no reset", rst_out, 0);
      @(negedge clk);
      chk("R6 kick one cycle", wdog_kick, 0);
      seen = 0;
      repeat (5) begin @(negedge clk); seen |= rst_out; end
      chk("R6 no later reset", seen, 0);
      chk("R6 flags unchanged", {cause_wdog, cause_soft}, 0);
   endtask

   task automatic t_soft();
      int n;
      wr_key(8'h5A); wr_key(8'hA5);
      chk("R7 rst next cycle", rst_out, 1);
      measure(n);
      chk("R7 pulse length", n, LEN);
      chk("R7 soft flag", cause_soft, 1);
      chk("R7 wdog flag untouched", cause_wdog, 0);
      clear_flags();
   endtask

   task automatic t_bad_pair();
      int n;
      wr_key(8'h1E); wr_key(8'hE1);
      @(negedge clk);
      wr_key(8'hE1);
      chk("R9 lone byte no kick", wdog_kick, 0);
      chk("R9 lone byte no reset", rst_out, 0);
      wr_key(8'hA5);
      chk("R8 bad pair resets", rst_out, 1);
      measure(n);
      chk("R8 pulse length", n, LEN);
      chk("R8 both flags", {cause_wdog, cause_soft}, 3);
      clear_flags();
   endtask

   task automatic t_ignore_in_reset();
      int n;
      wr_key(8'h5A); wr_key(8'hA5);
      repeat (2) @(negedge clk);
      wr_key(8'h1E);
      measure(n);
      clear_flags();
      wr_key(8'h5A); wr_key(8'hA5);
      chk("R9 write in reset dropped: soft", cause_soft, 1);
      chk("R9 write in reset dropped: wdog", cause_wdog, 0);
      measure(n);
      clear_flags();
   endtask

   task automatic t_restart();
      int n;
      expire();
      repeat (5) @(negedge clk);
      chk("R10 still in pulse", rst_out, 1);
      expire();
      measure(n);
      chk("R10 restarted length", n, LEN);
   endtask

   task automatic t_set_wins();
      int n;
      chk("R11 flag sticky through pulse", cause_wdog, 1);
      flag_clr = 2'b01; wdog_expired = 1; @(negedge clk);
      flag_clr = 2'b00; wdog_expired = 0;
      chk("R11 set beats clear", cause_wdog, 1);
      measure(n);
      clear_flags();
   endtask

   task automatic t_gpio();
      int seen;
      fuse_pin_mode = 0;
      power_on(1'b0);
      repeat (PU + 10) @(negedge clk);
      chk("R2 held pin extends power-up", rst_out, 1);
      chk("R4 gpio reads 1 in power-up", gpio_in, 1);
      rst_pin_n = 1;
      for (int i = 0; i < 60 && rst_out; i++) @(negedge clk);
      chk("R2 released after pin high", rst_out, 0);
      rst_pin_n = 0;
      seen = 0;
      repeat (10) begin @(negedge clk); seen |= rst_out; end
      chk("R4 pin ignored in gpio mode", seen, 0);
      chk("R4 gpio follows pin low", gpio_in, 0);
      rst_pin_n = 1; repeat (3) @(negedge clk);
      chk("R4 gpio follows pin high", gpio_in, 1);
      fuse_pin_mode = 1; rst_pin_n = 0; @(negedge clk);
      chk("R4 gpio is 1 in pin mode", gpio_in, 1);
      repeat (6) @(negedge clk);
      chk("R3 pin mode resets again", rst_out, 1);
      rst_pin_n = 1;
   endtask

   initial begin
      @(negedge clk);
      t_power_on();
      t_pin_mode();
      t_wdog();
      t_kick();
      t_soft();
      t_bad_pair();
      t_ignore_in_reset();
      t_restart();
      t_set_wins();
      t_gpio();
      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         checks++; failures++;
         $display("FAIL watchdog run did not finish actual=0 expected=1");
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end
endmodule